// File: doc/BRIEF.md
# Key-Protected Fabric Reset Control

This block is a small memory-mapped register slice. It holds a reset control register whose bits drive four separate reset lines into programmable logic. A write lock guards the control register. Software writes a fixed unlock key to one offset, then programs the control register. Afterwards it writes a different fixed key to another offset, which protects the register again.

The block leaves power-on reset locked, with every line held in reset. Software releases the fabric by unlocking the block and clearing the control bits. Each line is active low and comes from its own flip-flop, so the lines cannot glitch. A status offset reports the lock state. The control register can be read back at any time, locked or not. The bus port takes one transfer per cycle: address, write enable and write data go in, and read data comes back one clock later.

Top module: `keyed_reset_ctl`

## Requirements
- R1: After synchronous reset the block is locked (`locked` = 1), the control register holds 0xF and every `fab_rst_n` line is 0.
- R2: A write of exactly 0x0000DF0D to offset 0x008 clears `locked` at the clock edge that takes the write.
- R3: A write of exactly 0x0000767B to offset 0x004 sets `locked` at the clock edge that takes the write.
- R4: The lock state does not change after any of these writes:
  - a value other than 0x0000DF0D written to 0x008;
  - a value other than 0x0000767B written to 0x004;
  - either key written to the other key's offset.
- R5: While `locked` is 1, a write to offset 0x240 is ignored. The control register and the reset lines keep their values.
- R6: While `locked` is 0, a write to offset 0x240 stores write-data bits [3:0] in the control register. Bits [31:4] are discarded.
- R7: `fab_rst_n[i]` is the inverse of control bit i (bit i drives line i, for i = 0 to 3). Each line is a flip-flop, so it changes one clock after the control register changes, which is the second edge after the write.
- R8: Read data is registered and comes from the address presented in the previous cycle:
  - offset 0x240 returns the control register in bits [3:0], whether the block is locked or unlocked;
  - offset 0x00C returns `locked` in bit 0;
  - every other offset, including the two key offsets, returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_we | input | 1 | Write enable for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address from the previous cycle |
| fab_rst_n | output | 4 | Active-low reset lines to the fabric |
| locked | output | 1 | 1 while the control register is write-protected |

## Verification
The control register is written several times, some while locked and some while unlocked. Comparing the read-back value and the reset lines after each write separates a working lock from a lock that is missing or stuck. The key offsets receive the right key, a key that is off by one count, and each key swapped onto the other key's offset; this separates an exact compare from a partial compare or a swapped address decode. A walking-one pattern and a value with ones in the upper bits show that each bit drives only its own line and that bits [31:4] are dropped. The cycle just after a control write is sampled to confirm the extra register stage on the reset lines.

// File: rtl/krc_pkg.sv
package krc_pkg;

  // Decoded intent of the current bus cycle.
  typedef struct packed {
    logic wr_lock;
    logic wr_unlock;
    logic wr_ctrl;
    logic rd_ctrl;
    logic rd_stat;
  } krc_hit_t;

endpackage

// File: rtl/krc_decode.sv
module krc_decode
  import krc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LOCK_OFS   = 12'h004,
  parameter logic [ADDR_W-1:0] UNLOCK_OFS = 12'h008,
  parameter logic [ADDR_W-1:0] STAT_OFS   = 12'h00C,
  parameter logic [ADDR_W-1:0] CTRL_OFS   = 12'h240
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output krc_hit_t          hit
);

  always_comb begin
    hit.wr_lock   = we && (addr == LOCK_OFS);
    hit.wr_unlock = we && (addr == UNLOCK_OFS);
    hit.wr_ctrl   = we && (addr == CTRL_OFS);
    hit.rd_ctrl   = (addr == CTRL_OFS);
    hit.rd_stat   = (addr == STAT_OFS);
  end

endmodule

// File: rtl/krc_lock.sv
module krc_lock #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] LOCK_KEY   = 32'h0000_767B,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_DF0D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lock,
  input  logic              wr_unlock,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked_o
);

  logic lock_q;
  logic key_open;
  logic key_close;

  assign key_open  = wr_unlock && (wdata == UNLOCK_KEY);
  assign key_close = wr_lock && (wdata == LOCK_KEY);

  always_ff @(posedge clk) begin
    if (rst)            lock_q <= 1'b1;
    else if (key_open)  lock_q <= 1'b0;
    else if (key_close) lock_q <= 1'b1;
  end

  assign locked_o = lock_q;

  // R1: leaves reset locked
  a_r1_locked_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> locked_o);

  // R2: exact unlock key opens the lock
  a_r2_unlock_opens: assert property (@(posedge clk) disable iff (rst)
    (wr_unlock && wdata == UNLOCK_KEY) |=> !locked_o);

  // R3: exact lock key closes the lock
  a_r3_lock_closes: assert property (@(posedge clk) disable iff (rst)
    (wr_lock && wdata == LOCK_KEY) |=> locked_o);

  // R4: wrong values at the key offsets leave the state alone
  a_r4_bad_key_no_effect: assert property (@(posedge clk) disable iff (rst)
    ((wr_unlock && wdata != UNLOCK_KEY) || (wr_lock && wdata != LOCK_KEY))
      |=> $stable(locked_o));

endmodule

// File: rtl/krc_ctrl.sv
module krc_ctrl #(
  parameter int NUM_RST = 4,
  parameter logic [NUM_RST-1:0] CTRL_INIT = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_ctrl,
  input  logic               locked_i,
  input  logic [NUM_RST-1:0] wbits,
  output logic [NUM_RST-1:0] ctrl_o,
  output logic [NUM_RST-1:0] rst_n_o
);

  logic [NUM_RST-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)                        ctrl_q <= CTRL_INIT;
    else if (wr_ctrl && !locked_i)  ctrl_q <= wbits;
  end

  assign ctrl_o = ctrl_q;

  // R5: a protected register keeps its value
  a_r5_locked_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && locked_i) |=> $stable(ctrl_q));

  // R6: an open register takes the low write bits
  a_r6_open_write_stored: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !locked_i) |=> (ctrl_q == $past(wbits)));

  // One output flip-flop per reset line.
  for (genvar i = 0; i < NUM_RST; i++) begin : g_line
    logic line_q;

    always_ff @(posedge clk) begin
      if (rst) line_q <= ~CTRL_INIT[i];
      else     line_q <= ~ctrl_q[i];
    end

    assign rst_n_o[i] = line_q;

    // R7: each line follows its own bit, one clock behind
    a_r7_line_follows_bit: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (rst_n_o[i] == !$past(ctrl_q[i])));
  end

endmodule

// File: rtl/krc_rdmux.sv
module krc_rdmux #(
  parameter int DATA_W  = 32,
  parameter int NUM_RST = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_ctrl,
  input  logic               rd_stat,
  input  logic [NUM_RST-1:0] ctrl_i,
  input  logic               locked_i,
  output logic [DATA_W-1:0]  rdata_o
);

  localparam int CTRL_PAD = DATA_W - NUM_RST;
  localparam int STAT_PAD = DATA_W - 1;

  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rdata_d = '0;
    if (rd_ctrl)      rdata_d = {{CTRL_PAD{1'b0}}, ctrl_i};
    else if (rd_stat) rdata_d = {{STAT_PAD{1'b0}}, locked_i};
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  // R8: status read returns the lock bit from the address cycle
  a_r8_stat_read: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> (rdata_o == {{STAT_PAD{1'b0}}, $past(locked_i)}));

  // R8: unmapped offsets read as zero
  a_r8_other_zero: assert property (@(posedge clk) disable iff (rst)
    (!rd_stat && !rd_ctrl) |=> (rdata_o == '0));

endmodule

// File: rtl/keyed_reset_ctl.sv
module keyed_reset_ctl
  import krc_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int NUM_RST = 4,
  parameter logic [ADDR_W-1:0] LOCK_OFS   = 12'h004,
  parameter logic [ADDR_W-1:0] UNLOCK_OFS = 12'h008,
  parameter logic [ADDR_W-1:0] STAT_OFS   = 12'h00C,
  parameter logic [ADDR_W-1:0] CTRL_OFS   = 12'h240,
  parameter logic [DATA_W-1:0] LOCK_KEY   = 32'h0000_767B,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_DF0D,
  parameter logic [NUM_RST-1:0] CTRL_INIT = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_RST-1:0] fab_rst_n,
  output logic               locked
);

  krc_hit_t           hit;
  logic [NUM_RST-1:0] ctrl;

  krc_decode #(
    .ADDR_W(ADDR_W), .LOCK_OFS(LOCK_OFS), .UNLOCK_OFS(UNLOCK_OFS),
    .STAT_OFS(STAT_OFS), .CTRL_OFS(CTRL_OFS)
  ) u_decode (
    .addr(bus_addr), .we(bus_we), .hit(hit)
  );

  krc_lock #(
    .DATA_W(DATA_W), .LOCK_KEY(LOCK_KEY), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_lock (
    .clk(clk), .rst(rst), .wr_lock(hit.wr_lock), .wr_unlock(hit.wr_unlock),
    .wdata(bus_wdata), .locked_o(locked)
  );

  krc_ctrl #(
    .NUM_RST(NUM_RST), .CTRL_INIT(CTRL_INIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(hit.wr_ctrl), .locked_i(locked),
    .wbits(bus_wdata[NUM_RST-1:0]), .ctrl_o(ctrl), .rst_n_o(fab_rst_n)
  );

  krc_rdmux #(
    .DATA_W(DATA_W), .NUM_RST(NUM_RST)
  ) u_rdmux (
    .clk(clk), .rst(rst), .rd_ctrl(hit.rd_ctrl), .rd_stat(hit.rd_stat),
    .ctrl_i(ctrl), .locked_i(locked), .rdata_o(bus_rdata)
  );

endmodule

// File: tb/keyed_reset_ctl_test.sv
`timescale 1ns/1ps
module keyed_reset_ctl_test;

  localparam logic [11:0] A_LOCK   = 12'h004;
  localparam logic [11:0] A_UNLOCK = 12'h008;
  localparam logic [11:0] A_STAT   = 12'h00C;
  localparam logic [11:0] A_CTRL   = 12'h240;
  localparam logic [31:0] K_LOCK   = 32'h0000_767B;
  localparam logic [31:0] K_UNLOCK = 32'h0000_DF0D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  fab_rst_n;
  logic        locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t exp_q[$];
  logic rd_req = 1'b0;

  always #4 clk = ~clk;

  keyed_reset_ctl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fab_rst_n(fab_rst_n), .locked(locked)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver tasks start and end on a falling edge.
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp;
    it.tag = tag;
    exp_q.push_back(it);
    bus_addr = a;
    rd_req   = 1'b1;
    @(negedge clk);
    rd_req   = 1'b0;
  endtask

  // Monitor: the read result is visible after the edge that takes the address.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_req) begin
        rd_item_t it;
        #3;
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R8 monitor: actual %h expected none", bus_rdata);
        end else begin
          it = exp_q.pop_front();
          check(it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 locked", {31'b0, locked}, 32'd1);
    check("R1 fab_rst_n", {28'b0, fab_rst_n}, 32'h0);
    bus_read(A_CTRL, 32'hF, "R1 ctrl reset value");
    bus_read(A_STAT, 32'h1, "R8 status locked");

    // R5 locked write ignored
    bus_write(A_CTRL, 32'h0);
    @(negedge clk);
    check("R5 lines held", {28'b0, fab_rst_n}, 32'h0);
    bus_read(A_CTRL, 32'hF, "R5 ctrl unchanged");

    // R4 wrong keys
    bus_write(A_UNLOCK, 32'h0000_DF0C);
    check("R4 near-miss unlock", {31'b0, locked}, 32'd1);
    bus_write(A_LOCK, K_UNLOCK);
    check("R4 unlock key at lock offset", {31'b0, locked}, 32'd1);
    bus_write(A_UNLOCK, 32'h0001_DF0D);
    check("R4 upper bits set", {31'b0, locked}, 32'd1);

    // R2 unlock
    bus_write(A_UNLOCK, K_UNLOCK);
    check("R2 unlocked", {31'b0, locked}, 32'd0);
    bus_read(A_STAT, 32'h0, "R8 status unlocked");

    // R6/R7 write with upper bits, line timing
    bus_write(A_CTRL, 32'hFFFF_FFF5);
    check("R7 lines one clock late", {28'b0, fab_rst_n}, 32'h0);
    @(negedge clk);
    check("R7 lines follow 0x5", {28'b0, fab_rst_n}, 32'hA);
    bus_read(A_CTRL, 32'h5, "R6 upper bits dropped");

    // R7 release all, assert all
    bus_write(A_CTRL, 32'h0);
    @(negedge clk);
    check("R7 all released", {28'b0, fab_rst_n}, 32'hF);
    bus_write(A_CTRL, 32'h0F);
    @(negedge clk);
    check("R7 all asserted", {28'b0, fab_rst_n}, 32'h0);

    // R7 walking one: each bit drives only its line
    for (int i = 0; i < 4; i++) begin
      bus_write(A_CTRL, 32'(1) << i);
      @(negedge clk);
      check($sformatf("R7 walk bit %0d", i), {28'b0, fab_rst_n},
            {28'b0, ~(4'b0001 << i)});
    end

    // R4 while unlocked
    bus_write(A_LOCK, 32'h0000_767A);
    check("R4 near-miss lock", {31'b0, locked}, 32'd0);
    bus_write(A_UNLOCK, K_LOCK);
    check("R4 lock key at unlock offset", {31'b0, locked}, 32'd0);

    // R6 stores a mixed pattern
    bus_write(A_CTRL, 32'h6);
    @(negedge clk);
    check("R6 mixed pattern lines", {28'b0, fab_rst_n}, 32'h9);

    // R3 lock again
    bus_write(A_LOCK, K_LOCK);
    check("R3 locked again", {31'b0, locked}, 32'd1);
    bus_write(A_CTRL, 32'h3);
    @(negedge clk);
    check("R5 lines after locked write", {28'b0, fab_rst_n}, 32'h9);
    bus_read(A_CTRL, 32'h6, "R8 ctrl readable while locked");

    // R8 other offsets
    bus_read(12'h100, 32'h0, "R8 unmapped offset");
    bus_read(A_LOCK, 32'h0, "R8 lock key offset");
    bus_read(A_UNLOCK, 32'h0, "R8 unlock key offset");

    repeat (3) @(negedge clk);
    check("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

endmodule